// File: doc/BRIEF.md
# Conservative Load Ordering Queue

This block is a circular queue of memory operations kept in program order. Loads and stores take slots when they are decoded. Each store is tracked only by its address phase. The data phase of a store is handled elsewhere and has no effect on load ordering. When an effective address is computed, it is written into its slot.

A load may run ahead of older stores only under a conservative rule. Every older store still in the queue must have a known address, and the low address bits of each such store must differ from the load's low address bits. Only the low `CMP_W` bits are kept and compared, so a match on those bits counts as a conflict even when the full addresses differ. One older store with an unknown address holds back every younger load.

Each cycle the queue shows which loads may run. It grants the oldest one, and a load is never granted twice. Slots are freed from the head in order at commit. A flush drops every slot younger than a given index.

Top module: `ldq_top`

## Requirements
- R1: After reset the queue is empty: `alloc_ready`=1, `alloc_idx`=0, `grant_valid`=0 and `load_ok`=0. Each accepted allocation takes slot `alloc_idx`, and `alloc_idx` then advances by one, modulo DEPTH.
- R2: While DEPTH slots are held, `alloc_ready` is 0 and an allocation request changes nothing, including `alloc_idx`.
- R3: `commit_valid` frees the oldest slot, so the next slot becomes the oldest. A commit on an empty queue is ignored. An empty queue never grants.
- R4: A load whose address has not been written is never granted.
- R5: A load is blocked while any older store in the queue has an unknown address.
- R6: A load is blocked when an older store's low CMP_W (12) address bits equal the load's low bits, even if the upper bits differ.
- R7: A load with a known address is allowed (`load_ok` bit set) when every older store has a known address with different low bits. Younger stores have no effect.
- R8: `grant_idx` is the oldest allowed load, counted from the head. A granted load is marked and is never granted again.
- R9: `flush_valid` with `flush_idx` on a held slot removes every slot younger than `flush_idx` and keeps that slot itself. The next allocation then goes to `flush_idx`+1. Allocation and commit requests in the flush cycle are ignored. A flush naming an empty slot is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request a new slot at the tail |
| alloc_store | input | 1 | 1 = the new slot is a store, 0 = a load |
| alloc_ready | output | 1 | A slot is free |
| alloc_idx | output | IDX_W | Slot the next allocation will take |
| addr_valid | input | 1 | Address write for a slot |
| addr_idx | input | IDX_W | Slot receiving the address |
| addr_value | input | ADDR_W | Effective address; only the low CMP_W bits are kept |
| commit_valid | input | 1 | Free the oldest slot |
| flush_valid | input | 1 | Drop the slots younger than flush_idx |
| flush_idx | input | IDX_W | Youngest slot that survives the flush |
| load_ok | output | DEPTH | Per-slot permission for a load to execute |
| grant_valid | output | 1 | A load is granted this cycle |
| grant_idx | output | IDX_W | Slot of the granted load |

## Verification
The bench aims at the ordering corners. It checks a store whose address arrives after the load's address, which a design that ignores unknown addresses would grant too early. It checks addresses that differ only above bit 11, which a full-width comparator would let through. It checks a younger store with an unknown address, which a design that confuses age with index would wrongly block on. It checks two loads released in the same cycle, where a wrong age order or a missing issued mark shows up as a wrong or repeated grant. It also runs a flush together with an allocation and a commit in the same cycle, and a full queue that is offered one more allocation. A long pseudo-random sweep with colliding low address bits and head wrap-around is compared every cycle against an arithmetic model of the queue.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

   // Per-slot status bits
   typedef struct packed {
      logic valid;    // slot holds a live operation
      logic is_st;    // 1 = store, 0 = load
      logic addr_ok;  // effective address has been written
      logic issued;   // load has already been granted
   } ldq_flags_t;

endpackage

// File: rtl/ldq_ctrl.sv
module ldq_ctrl #(
   parameter  int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_req,
   input  logic             commit_req,
   input  logic             flush_req,
   input  logic             flush_hit,
   input  logic [IDX_W-1:0] flush_idx,
   output logic             alloc_fire,
   output logic             commit_fire,
   output logic             flush_fire,
   output logic             alloc_ready,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] tail,
   output logic [CNT_W-1:0] count,
   output logic [DEPTH-1:0] kill_vec
);

   logic [IDX_W-1:0] flush_age;

   assign flush_age   = flush_idx - head;
   assign alloc_ready = (count != CNT_W'(DEPTH));
   assign flush_fire  = flush_req & flush_hit;
   assign alloc_fire  = alloc_req & alloc_ready & ~flush_fire;
   assign commit_fire = commit_req & (count != '0) & ~flush_fire;

   for (genvar i = 0; i < DEPTH; i++) begin : g_kill
      logic [IDX_W-1:0] age_i;
      assign age_i       = IDX_W'(i) - head;
      assign kill_vec[i] = flush_fire & (age_i > flush_age);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else if (flush_fire) begin
         tail  <= flush_idx + 1'b1;
         count <= CNT_W'(flush_age) + 1'b1;
      end else begin
         head  <= head + IDX_W'(commit_fire);
         tail  <= tail + IDX_W'(alloc_fire);
         count <= count + CNT_W'(alloc_fire) - CNT_W'(commit_fire);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));  // R2
   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(DEPTH) && !commit_req && !flush_req) |=> count == CNT_W'(DEPTH));  // R2
   AST_FLUSH_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      flush_fire |=> count <= $past(count));  // R9

endmodule

// File: rtl/ldq_entries.sv
module ldq_entries
   import ldq_pkg::*;
#(
   parameter  int DEPTH = 16,
   parameter  int CMP_W = 12,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        alloc_fire,
   input  logic                        alloc_store,
   input  logic [IDX_W-1:0]            tail,
   input  logic                        commit_fire,
   input  logic [IDX_W-1:0]            head,
   input  logic [DEPTH-1:0]            kill_vec,
   input  logic                        upd_valid,
   input  logic [IDX_W-1:0]            upd_idx,
   input  logic [CMP_W-1:0]            upd_addr,
   input  logic                        grant_valid,
   input  logic [IDX_W-1:0]            grant_idx,
   output ldq_flags_t [DEPTH-1:0]      flags,
   output logic [DEPTH-1:0][CMP_W-1:0] addrs
);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      ldq_flags_t       ent_q;
      logic [CMP_W-1:0] adr_q;
      logic             take, drop, upd, grt;

      assign take = alloc_fire && (tail == IDX_W'(i));
      assign drop = kill_vec[i] || (commit_fire && (head == IDX_W'(i)));
      assign upd  = upd_valid && (upd_idx == IDX_W'(i)) && ent_q.valid;
      assign grt  = grant_valid && (grant_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q <= '0;
            adr_q <= '0;
         end else if (take) begin
            ent_q <= '{valid: 1'b1, is_st: alloc_store, addr_ok: 1'b0, issued: 1'b0};
         end else if (drop) begin
            ent_q.valid <= 1'b0;
         end else begin
            if (upd) begin
               ent_q.addr_ok <= 1'b1;
               adr_q         <= upd_addr;
            end
            if (grt) ent_q.issued <= 1'b1;
         end
      end

      assign flags[i] = ent_q;
      assign addrs[i] = adr_q;
   end

endmodule

// File: rtl/ldq_conflict.sv
module ldq_conflict
   import ldq_pkg::*;
#(
   parameter  int DEPTH = 16,
   parameter  int CMP_W = 12,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [IDX_W-1:0]            head,
   input  ldq_flags_t [DEPTH-1:0]      flags,
   input  logic [DEPTH-1:0][CMP_W-1:0] addrs,
   output logic [DEPTH-1:0]            ok_vec
);

   for (genvar i = 0; i < DEPTH; i++) begin : g_ld
      logic [IDX_W-1:0] age_i;
      logic             blk;

      assign age_i = IDX_W'(i) - head;

      always_comb begin
         blk = 1'b0;
         for (int j = 0; j < DEPTH; j++) begin
            logic [IDX_W-1:0] age_j;
            age_j = IDX_W'(j) - head;
            if ((age_j < age_i) && flags[j].valid && flags[j].is_st &&
                (!flags[j].addr_ok || (addrs[j] == addrs[i])))
               blk = 1'b1;
         end
      end

      assign ok_vec[i] = flags[i].valid & ~flags[i].is_st & flags[i].addr_ok &
                         ~flags[i].issued & ~blk;
   end

endmodule

// File: rtl/ldq_pick.sv
module ldq_pick #(
   parameter  int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [IDX_W-1:0] head,
   input  logic [DEPTH-1:0] ok_vec,
   output logic             grant_valid,
   output logic [IDX_W-1:0] grant_idx
);

   // scan from youngest to oldest so the oldest hit is the last one written
   always_comb begin
      grant_valid = 1'b0;
      grant_idx   = head;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         logic [IDX_W-1:0] slot;
         slot = head + IDX_W'(k);
         if (ok_vec[slot]) begin
            grant_valid = 1'b1;
            grant_idx   = slot;
         end
      end
   end

endmodule

// File: rtl/ldq_top.sv
module ldq_top
   import ldq_pkg::*;
#(
   parameter  int DEPTH  = 16,
   parameter  int ADDR_W = 32,
   parameter  int CMP_W  = 12,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int CNT_W  = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic              alloc_store,
   output logic              alloc_ready,
   output logic [IDX_W-1:0]  alloc_idx,
   input  logic              addr_valid,
   input  logic [IDX_W-1:0]  addr_idx,
   input  logic [ADDR_W-1:0] addr_value,
   input  logic              commit_valid,
   input  logic              flush_valid,
   input  logic [IDX_W-1:0]  flush_idx,
   output logic [DEPTH-1:0]  load_ok,
   output logic              grant_valid,
   output logic [IDX_W-1:0]  grant_idx
);

   if ((1 << IDX_W) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("ldq_top: DEPTH must be a power of two, at least 2");
   end
   if (CMP_W < 1 || CMP_W > ADDR_W) begin : g_bad_cmp
      $error("ldq_top: CMP_W must lie in 1..ADDR_W");
   end

   logic                        alloc_fire, commit_fire, flush_fire;
   logic [IDX_W-1:0]            head, tail;
   logic [CNT_W-1:0]            count;
   logic [DEPTH-1:0]            kill_vec;
   ldq_flags_t [DEPTH-1:0]      flags;
   logic [DEPTH-1:0][CMP_W-1:0] addrs;

   ldq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .alloc_req(alloc_valid), .commit_req(commit_valid),
      .flush_req(flush_valid), .flush_hit(flags[flush_idx].valid), .flush_idx(flush_idx),
      .alloc_fire(alloc_fire), .commit_fire(commit_fire), .flush_fire(flush_fire),
      .alloc_ready(alloc_ready), .head(head), .tail(tail), .count(count),
      .kill_vec(kill_vec)
   );

   ldq_entries #(.DEPTH(DEPTH), .CMP_W(CMP_W)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .alloc_fire(alloc_fire), .alloc_store(alloc_store), .tail(tail),
      .commit_fire(commit_fire), .head(head), .kill_vec(kill_vec),
      .upd_valid(addr_valid), .upd_idx(addr_idx), .upd_addr(addr_value[CMP_W-1:0]),
      .grant_valid(grant_valid), .grant_idx(grant_idx),
      .flags(flags), .addrs(addrs)
   );

   ldq_conflict #(.DEPTH(DEPTH), .CMP_W(CMP_W)) u_cmp (
      .head(head), .flags(flags), .addrs(addrs), .ok_vec(load_ok)
   );

   ldq_pick #(.DEPTH(DEPTH)) u_pick (
      .head(head), .ok_vec(load_ok), .grant_valid(grant_valid), .grant_idx(grant_idx)
   );

   assign alloc_idx = tail;

   AST_GRANT_READY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> (flags[grant_idx].valid && !flags[grant_idx].is_st && flags[grant_idx].addr_ok));  // R4
   AST_GRANT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |=> !(grant_valid && grant_idx == $past(grant_idx)));  // R8
   AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> !grant_valid);  // R3
   AST_GRANT_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> load_ok[grant_idx]);  // R7

endmodule

// File: tb/ldq_top_tb.sv
module ldq_top_tb;
   localparam int D  = 16;
   localparam int IW = 4;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          alloc_valid, alloc_store, alloc_ready;
   logic [IW-1:0] alloc_idx;
   logic          addr_valid;
   logic [IW-1:0] addr_idx;
   logic [AW-1:0] addr_value;
   logic          commit_valid, flush_valid;
   logic [IW-1:0] flush_idx;
   logic [D-1:0]  load_ok;
   logic          grant_valid;
   logic [IW-1:0] grant_idx;

   always #10 clk = ~clk;  // 50 MHz

   ldq_top #(.DEPTH(D), .ADDR_W(AW), .CMP_W(12)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_store(alloc_store),
      .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
      .addr_valid(addr_valid), .addr_idx(addr_idx), .addr_value(addr_value),
      .commit_valid(commit_valid), .flush_valid(flush_valid), .flush_idx(flush_idx),
      .load_ok(load_ok), .grant_valid(grant_valid), .grant_idx(grant_idx)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // reference model
   bit        mv[D], ms[D], mk[D], mi[D];
   bit [11:0] ma[D];
   int        mh, mt, mc;
   bit        eg_v;
   int        eg_i;

   task automatic chk(input bit ok, input string r, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
      end
   endtask

   function automatic bit m_blocked(int i);
      int age = (i - mh) & (D - 1);
      for (int k = 0; k < age; k++) begin
         int j = (mh + k) & (D - 1);
         if (mv[j] && ms[j] && (!mk[j] || ma[j] == ma[i])) return 1'b1;
      end
      return 1'b0;
   endfunction

   function automatic bit m_ok(int i);
      return mv[i] && !ms[i] && mk[i] && !mi[i] && !m_blocked(i);
   endfunction

   task automatic compare();
      logic [D-1:0] ev;
      ev   = '0;
      eg_v = 1'b0;
      eg_i = 0;
      for (int i = 0; i < D; i++) ev[i] = m_ok(i);
      for (int k = D - 1; k >= 0; k--) begin
         int s = (mh + k) & (D - 1);
         if (ev[s]) begin eg_v = 1'b1; eg_i = s; end
      end
      chk(alloc_ready == (mc < D), "R2", "alloc_ready", 32'(alloc_ready), 32'(mc < D));
      chk(alloc_idx == IW'(mt), "R1", "alloc_idx", 32'(alloc_idx), 32'(mt));
      chk(load_ok == ev, "R7", "load_ok", 32'(load_ok), 32'(ev));
      chk(grant_valid == eg_v, "R8", "grant_valid", 32'(grant_valid), 32'(eg_v));
      if (eg_v) chk(grant_idx == IW'(eg_i), "R8", "grant_idx", 32'(grant_idx), 32'(eg_i));
   endtask

   task automatic cyc(input bit a_v, input bit a_s, input bit u_v, input int u_i,
                      input logic [31:0] u_a, input bit c_v, input bit f_v, input int f_i);
      bit ffire;
      int fage;
      compare();
      alloc_valid  = a_v;
      alloc_store  = a_s;
      addr_valid   = u_v;
      addr_idx     = IW'(u_i);
      addr_value   = u_a;
      commit_valid = c_v;
      flush_valid  = f_v;
      flush_idx    = IW'(f_i);
      @(posedge clk);
      ffire = f_v && mv[f_i & (D - 1)];
      if (u_v && mv[u_i & (D - 1)]) begin
         mk[u_i & (D - 1)] = 1'b1;
         ma[u_i & (D - 1)] = u_a[11:0];
      end
      if (eg_v) mi[eg_i] = 1'b1;
      if (ffire) begin
         fage = (f_i - mh) & (D - 1);
         for (int k = fage + 1; k < D; k++) mv[(mh + k) & (D - 1)] = 1'b0;
         mt = (f_i + 1) & (D - 1);
         mc = fage + 1;
      end else begin
         int c0 = mc;
         if (c_v && c0 > 0) begin
            mv[mh] = 1'b0;
            mh = (mh + 1) & (D - 1);
            mc--;
         end
         if (a_v && c0 < D) begin
            mv[mt] = 1'b1; ms[mt] = a_s; mk[mt] = 1'b0; mi[mt] = 1'b0;
            mt = (mt + 1) & (D - 1);
            mc++;
         end
      end
      @(negedge clk);
   endtask

   task automatic idle();                         cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask
   task automatic alloc(input bit st);            cyc(1, st, 0, 0, 0, 0, 0, 0); endtask
   task automatic upd(input int i, input logic [31:0] a); cyc(0, 0, 1, i, a, 0, 0, 0); endtask
   task automatic commit();                       cyc(0, 0, 0, 0, 0, 1, 0, 0); endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      rst_n = 1'b0;
      alloc_valid = 0; alloc_store = 0; addr_valid = 0; addr_idx = 0; addr_value = 0;
      commit_valid = 0; flush_valid = 0; flush_idx = 0;
      for (int i = 0; i < D; i++) begin mv[i] = 0; ms[i] = 0; mk[i] = 0; mi[i] = 0; ma[i] = 0; end
      mh = 0; mt = 0; mc = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(alloc_ready == 1'b1, "R1", "reset alloc_ready", 32'(alloc_ready), 1);
      chk(alloc_idx == 0, "R1", "reset alloc_idx", 32'(alloc_idx), 0);
      chk(grant_valid == 1'b0, "R1", "reset grant_valid", 32'(grant_valid), 0);
      chk(load_ok == '0, "R1", "reset load_ok", 32'(load_ok), 0);

      // R5 / R7: store address arrives after load address
      alloc(1); alloc(0);
      upd(1, 32'h100);
      chk(grant_valid == 0, "R5", "grant with unknown older store", 32'(grant_valid), 0);
      upd(0, 32'h200);
      chk(grant_valid && grant_idx == 1, "R7", "grant idx after store resolves", 32'(grant_idx), 1);
      idle();
      chk(grant_valid == 0, "R8", "regrant of issued load", 32'(grant_valid), 0);
      commit(); commit();
      commit();  // on empty queue: ignored
      chk(alloc_idx == 2 && alloc_ready, "R3", "alloc_idx after commits", 32'(alloc_idx), 2);

      // R6: low 12 bits match, upper differ
      alloc(1); alloc(0);
      upd(2, 32'h0000_5123); upd(3, 32'h0001_1123);
      chk(grant_valid == 0, "R6", "grant on partial match", 32'(grant_valid), 0);
      commit();
      chk(grant_valid && grant_idx == 3, "R3", "grant after store commit", 32'(grant_idx), 3);
      commit();

      // R4: load without address; younger store ignored
      alloc(0); idle();
      chk(grant_valid == 0, "R4", "grant of addressless load", 32'(grant_valid), 0);
      alloc(1);
      upd(4, 32'h40);
      chk(grant_valid && grant_idx == 4, "R7", "younger unknown store ignored", 32'(grant_idx), 4);
      idle(); commit();

      // R8: two loads released together
      alloc(0); alloc(0);
      upd(6, 32'h10); upd(7, 32'h20);
      chk(grant_valid == 0, "R5", "loads behind unknown store", 32'(grant_valid), 0);
      upd(5, 32'h30);
      chk(grant_valid && grant_idx == 6, "R8", "oldest first", 32'(grant_idx), 6);
      idle();
      chk(grant_valid && grant_idx == 7, "R8", "second load next", 32'(grant_idx), 7);
      idle();

      // R9: flush with concurrent alloc and commit
      alloc(0);
      cyc(1, 0, 0, 0, 0, 1, 1, 6);
      chk(alloc_idx == 7, "R9", "tail after flush", 32'(alloc_idx), 7);
      cyc(0, 0, 0, 0, 0, 0, 1, 12);  // flush of empty slot: ignored
      chk(alloc_idx == 7, "R9", "flush of empty slot", 32'(alloc_idx), 7);
      commit(); commit();

      // R2: fill to DEPTH
      for (int i = 0; i < D; i++) alloc(i[0]);
      chk(alloc_ready == 0, "R2", "alloc_ready when full", 32'(alloc_ready), 0);
      alloc(0);
      chk(alloc_idx == 7, "R2", "alloc_idx unchanged when full", 32'(alloc_idx), 7);
      for (int i = 0; i < D; i++) commit();

      // pseudo-random sweep against the model
      r = 32'h1234_5678;
      for (int n = 0; n < 4000; n++) begin
         int span, ui, fi;
         r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
         span = (mc > 0) ? mc : 1;
         ui = (mh + int'(r[11:8]) % span) & (D - 1);
         fi = (mh + int'(r[27:24]) % span) & (D - 1);
         cyc(r[0] | r[1], r[2], r[3] | r[4], ui,
             {r[31:16], 4'h0, 2'b00, r[20:19], 4'h0},
             r[5] & r[6], (r[15:12] == 0), fi);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule